// File: doc/BRIEF.md
# Partial-Window Update Command Sequencer

This block drives an e-paper controller's command port when a rectangular region of the panel is to be refreshed on its own. When it is given a region (x, y, width, height) on a start pulse, it emits a fixed series of command and parameter bytes. The series selects the two-plane panel configuration, enters partial mode, programs the window bounds, sets the VCOM/data interval and opens the first data transmission. It then replays the old contents of that region from a local byte memory, so that the controller knows what the region showed before. Rendering the new contents is left to other logic, which takes over once `done` pulses.

Every byte leaves on a valid/ready stream. A data/command flag goes with each byte: 0 marks a command opcode, and 1 marks a parameter or pixel byte. A narrow-panel input selects the shorter window encoding, which leaves out the horizontal high bytes. The host fills the old-data memory through a simple write port. A clear input zeroes the whole memory, which is how the first partial update after a full refresh starts from a blank region.

Top module: `partial_window_seq`

## Requirements
- R1: After reset `out_valid`, `busy`, `done` and `err` are all 0.
- R2: An accepted start with nonzero width and height produces bytes in this order: command 0x00, parameter 0x0F, command 0x91, command 0x90, the window parameters, command 0x50, parameter 0x97, command 0x10. `out_dc` is 0 on commands and 1 on parameters and data.
- R3: The window's horizontal start byte is x with bits [2:0] cleared. The horizontal end byte is the low byte of x+w-1 with bits [2:0] set to 1.
- R4: With `narrow`=0 the window carries 9 parameters in this order: x-start high byte, x-start low byte, x-end high byte, x-end low byte, y-start high, y-start low, y-end high, y-end low (y-end = y+h-1), then 0x38.
- R5: With `narrow`=1 the window carries 7 parameters: the two x high bytes are left out and the remaining order is kept.
- R6: After command 0x10 the block sends ceil(w/8)*h data bytes (`out_dc`=1). They are read from old-data memory addresses 0, 1, 2, … in order.
- R7: A pulse on `old_clr` sets every old-data byte to 0x00, so the next region replays only zeros.
- R8: A start in which width or height is zero raises `err` for exactly one cycle, one cycle after the start. It emits no byte.
- R9: `done` pulses for one cycle in the cycle after the last data byte is accepted. `out_valid` is 0 in that cycle.
- R10: While `out_valid`=1 and `out_ready`=0, `out_byte` and `out_dc` hold their values and `out_valid` stays 1.
- R11: A start pulse that arrives while a sequence is in progress is ignored. The stream in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence for the region given on the region inputs |
| narrow | input | 1 | 1 selects the 7-parameter window encoding |
| reg_x | input | CW | Region left column |
| reg_y | input | CW | Region top row |
| reg_w | input | CW | Region width in pixels |
| reg_h | input | CW | Region height in lines |
| old_we | input | 1 | Write strobe for the old-data memory |
| old_addr | input | AW | Old-data write address |
| old_wdata | input | 8 | Old-data write byte |
| old_clr | input | 1 | Zero the whole old-data memory |
| out_byte | output | 8 | Stream byte |
| out_dc | output | 1 | 0 = command, 1 = parameter/data |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse after the last byte is accepted |
| err | output | 1 | One-cycle pulse on a zero-area request |

## Verification
A wrong header index shows up at the first accepted byte after the fault as an opcode in the wrong place or a flipped `out_dc`. In narrow mode a wrong skip shows as the header being two bytes too long or too short, which moves the 0x38, 0x50 and 0x10 bytes by two positions. A wrong column or line counter changes the number of data bytes, and `done` then arrives early or late compared with the ceil(w/8)*h count. Address or clear faults show up in the first data bytes after 0x10.

// File: rtl/partial_window_seq.sv
module partial_window_seq #(
  parameter int CW    = 16,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          narrow,
  input  logic [CW-1:0] reg_x,
  input  logic [CW-1:0] reg_y,
  input  logic [CW-1:0] reg_w,
  input  logic [CW-1:0] reg_h,
  input  logic          old_we,
  input  logic [AW-1:0] old_addr,
  input  logic [7:0]    old_wdata,
  input  logic          old_clr,
  output logic [7:0]    out_byte,
  output logic          out_dc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          busy,
  output logic          done,
  output logic          err
);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_OLD} st_t;

  st_t           st;
  logic [3:0]    idx;
  logic [CW-1:0] lx, ly, lw, lh, col, line;
  logic          lnar;
  logic [AW-1:0] rd;
  logic [7:0]    mem [DEPTH];

  logic [15:0] xs16, xe16, ys16, ye16;
  logic [CW-1:0] bpl;
  logic fire, last_hdr, last_old;
  logic [7:0] hbyte;
  logic       hdc;

  assign xs16 = 16'(lx);
  assign xe16 = 16'(lx + lw - 1'b1);
  assign ys16 = 16'(ly);
  assign ye16 = 16'(ly + lh - 1'b1);
  assign bpl  = (lw + CW'(7)) >> 3;

  assign out_valid = (st != S_IDLE);
  assign busy      = out_valid;
  assign fire      = out_valid && out_ready;
  assign last_hdr  = (idx == 4'd15);
  assign last_old  = (col == bpl - 1'b1) && (line == lh - 1'b1);

  always_comb begin
    hdc = 1'b1;
    unique case (idx)
      4'd0:  begin hbyte = 8'h00; hdc = 1'b0; end
      4'd1:  hbyte = 8'h0F;
      4'd2:  begin hbyte = 8'h91; hdc = 1'b0; end
      4'd3:  begin hbyte = 8'h90; hdc = 1'b0; end
      4'd4:  hbyte = xs16[15:8];
      4'd5:  hbyte = {xs16[7:3], 3'b000};
      4'd6:  hbyte = xe16[15:8];
      4'd7:  hbyte = {xe16[7:3], 3'b111};
      4'd8:  hbyte = ys16[15:8];
      4'd9:  hbyte = ys16[7:0];
      4'd10: hbyte = ye16[15:8];
      4'd11: hbyte = ye16[7:0];
      4'd12: hbyte = 8'h38;
      4'd13: begin hbyte = 8'h50; hdc = 1'b0; end
      4'd14: hbyte = 8'h97;
      default: begin hbyte = 8'h10; hdc = 1'b0; end
    endcase
  end

  assign out_byte = (st == S_OLD) ? mem[rd] : hbyte;
  assign out_dc   = (st == S_OLD) ? 1'b1 : hdc;

  always_ff @(posedge clk) begin
    if (old_clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (old_we) begin
      mem[old_addr] <= old_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; col <= '0; line <= '0; rd <= '0;
      lx <= '0; ly <= '0; lw <= '0; lh <= '0; lnar <= 1'b0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          if (reg_w == '0 || reg_h == '0) begin
            err <= 1'b1;
          end else begin
            lx <= reg_x; ly <= reg_y; lw <= reg_w; lh <= reg_h;
            lnar <= narrow; idx <= '0; st <= S_HDR;
          end
        end
        S_HDR: if (fire) begin
          if (last_hdr) begin
            st <= S_OLD; col <= '0; line <= '0; rd <= '0;
          end else if (lnar && (idx == 4'd3 || idx == 4'd5)) begin
            idx <= idx + 4'd2;
          end else begin
            idx <= idx + 4'd1;
          end
        end
        default: if (fire) begin
          rd <= rd + 1'b1;
          if (col == bpl - 1'b1) begin
            col <= '0;
            line <= line + 1'b1;
          end else begin
            col <= col + 1'b1;
          end
          if (last_old) begin
            st <= S_IDLE;
            done <= 1'b1;
          end
        end
      endcase
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid && !done && !err);

  assert_first_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_byte == 8'h00 && !out_dc);

  assert_zero_area_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && start && (reg_w == '0 || reg_h == '0)) |=> err && !out_valid);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid && !err);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !old_we && !old_clr) |=>
      out_valid && $stable(out_byte) && $stable(out_dc));

  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && start) |=> $stable(lw) && $stable(lh) && !err);

endmodule

// File: tb/partial_window_seq_tb.sv
`timescale 1ns/1ps
module partial_window_seq_tb;
  localparam int CW = 16;
  localparam int DEPTH = 256;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, narrow = 0, old_we = 0, old_clr = 0, out_ready = 0;
  logic [CW-1:0] reg_x = 0, reg_y = 0, reg_w = 0, reg_h = 0;
  logic [AW-1:0] old_addr = 0;
  logic [7:0] old_wdata = 0;
  logic [7:0] out_byte;
  logic out_dc, out_valid, busy, done, err;

  partial_window_seq #(.CW(CW), .DEPTH(DEPTH), .AW(AW)) u_dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] tbmem [DEPTH];
  logic [8:0] exp_q [1024];
  int exp_n;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic push(input bit dc, input logic [7:0] b);
    exp_q[exp_n] = {dc, b};
    exp_n++;
  endtask

  task automatic build(input int x, input int y, input int w, input int h, input bit nar, input bit zeroed);
    int xe, ye, n;
    xe = x + w - 1; ye = y + h - 1; exp_n = 0;
    push(0, 8'h00); push(1, 8'h0F); push(0, 8'h91); push(0, 8'h90);
    if (!nar) push(1, 8'(x >> 8));
    push(1, 8'(x & 8'hF8));
    if (!nar) push(1, 8'(xe >> 8));
    push(1, 8'((xe & 8'hFF) | 7));
    push(1, 8'(y >> 8)); push(1, 8'(y & 8'hFF));
    push(1, 8'(ye >> 8)); push(1, 8'(ye & 8'hFF));
    push(1, 8'h38); push(0, 8'h50); push(1, 8'h97); push(0, 8'h10);
    n = ((w + 7) / 8) * h;
    for (int i = 0; i < n; i++) push(1, zeroed ? 8'h00 : tbmem[i % DEPTH]);
  endtask

  task automatic kick(input int x, input int y, input int w, input int h, input bit nar);
    @(negedge clk);
    reg_x = CW'(x); reg_y = CW'(y); reg_w = CW'(w); reg_h = CW'(h); narrow = nar; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // mode 0: ready always; 1: alternate; 2: stall 3 of every 7
  task automatic collect(input int mode, input string req, input int inject_at);
    int got, cyc, hdr;
    logic [8:0] prev;
    bit stalled;
    got = 0; cyc = 0; stalled = 0; prev = '0;
    hdr = exp_n;
    for (int i = 0; i < exp_n; i++) if (exp_q[i] == 9'h010) begin hdr = i + 1; break; end
    while (got < exp_n && cyc < 5000) begin
      out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : ((cyc % 7) >= 3);
      if (got == inject_at && inject_at >= 0) begin
        reg_x = 16'h0040; reg_w = 16'd99; reg_h = 16'd9; narrow = ~narrow; start = 1;
      end else start = 0;
      #0.1;
      if (stalled)
        chk(out_valid && {out_dc, out_byte} == prev, "R10", "held byte", {out_dc, out_byte}, prev);
      if (!out_valid) begin
        chk(0, req, "valid dropped", got, exp_n);
        got = exp_n;
      end else begin
        if (out_ready) begin
          chk({out_dc, out_byte} == exp_q[got], got < hdr ? req : "R6",
              $sformatf("byte %0d", got), {out_dc, out_byte}, exp_q[got]);
          got++;
        end
        stalled = !out_ready;
        prev = {out_dc, out_byte};
      end
      @(negedge clk);
      cyc++;
    end
    start = 0; out_ready = 0;
    chk(done == 1'b1 && out_valid == 1'b0, "R9", "done after last byte", {done, out_valid}, 2);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single cycle", done, 0);
  endtask

  task automatic t_reset;
    chk(!out_valid && !busy && !done && !err, "R1", "reset outputs", {out_valid, busy, done, err}, 0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      old_we = 1; old_addr = AW'(i); old_wdata = 8'(i * 7 + 3); tbmem[i] = 8'(i * 7 + 3);
    end
    @(negedge clk); old_we = 0;
  endtask

  task automatic t_normal;
    build(13, 5, 20, 3, 0, 0);
    kick(13, 5, 20, 3, 0);
    collect(0, "R4", -1);
    chk(exp_q[5] == 9'h108 && exp_q[7] == 9'h127, "R3", "bound bytes", exp_q[7], 9'h127);
  endtask

  task automatic t_narrow;
    build(37, 291, 9, 2, 1, 0);
    kick(37, 291, 9, 2, 1);
    collect(1, "R5", -1);
  endtask

  task automatic t_high_stall;
    build(16'h1F3, 16'h100, 16'h30, 1, 0, 0);
    kick(16'h1F3, 16'h100, 16'h30, 1, 0);
    collect(2, "R3", -1);
  endtask

  task automatic t_clear;
    @(negedge clk); old_clr = 1;
    @(negedge clk); old_clr = 0;
    build(8, 2, 17, 4, 0, 1);
    kick(8, 2, 17, 4, 0);
    collect(2, "R7", -1);
  endtask

  task automatic t_zero;
    kick(10, 10, 0, 5, 0);
    chk(err == 1'b1 && !out_valid, "R8", "err on zero width", {err, out_valid}, 2);
    @(negedge clk);
    chk(err == 1'b0 && !out_valid, "R8", "err single, no output", {err, out_valid}, 0);
    kick(10, 10, 5, 0, 1);
    chk(err == 1'b1 && !out_valid, "R8", "err on zero height", {err, out_valid}, 2);
    repeat (3) @(negedge clk);
    chk(!out_valid && !err, "R8", "still idle", {err, out_valid}, 0);
  endtask

  task automatic t_busy_start;
    build(24, 1, 16, 2, 1, 1);
    kick(24, 1, 16, 2, 1);
    collect(0, "R11", 6);
    chk(!out_valid, "R11", "no second sequence", out_valid, 0);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_normal();
    t_narrow();
    t_high_stall();
    t_clear();
    t_zero();
    t_busy_start();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule